// File: doc/BRIEF.md
# SDRAM Window Bus Interface

This block is one slice of an external bus controller. When a 3-bit space-select field picks the SDRAM mode, four adjacent 2-Mbyte external areas (areas 2 to 5, byte addresses 0x400000 to 0xBFFFFF) are merged into one 8-Mbyte synchronous DRAM window. The chip-select pins that normally serve those areas carry the SDRAM command lines instead. The area-2 pin carries RAS, the area-3 pin CAS, the area-4 pin WE, and the area-5 pin the SDRAM clock. The output-enable pin becomes the clock-enable line.

The CPU side presents one access at a time on a valid/ready request channel: a byte address, a direction, two byte enables and 16-bit write data. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` stays low while an access is in flight, and also while an earlier response is still waiting for `rsp_ready`. Each hit runs a single-word sequence: ACTIVE, one tRCD gap, READ or WRITE, then PRECHARGE. For a read, the block waits the programmed CAS latency before it samples the data. The response channel holds `rsp_valid` and `rsp_rdata` steady until `rsp_ready` is high. A request that misses the window is consumed without touching the command pins, and `err` pulses for one cycle. No response follows such a request.

The bus is 16 bits wide and follows the area-2 width. No wait states of any kind are added inside the window. Refresh and mode-register programming belong to other logic.

Top module: `sdwin_bus_if`

## Requirements
- R1: With `space_sel` = 3'b100 the window is enabled. `pin_oe_n` (CKE) is 1 and `pin_cs_n[3]` follows `clk`. With any other code, including the reserved 3'b111, `pin_cs_n` is 4'b1111 and `pin_oe_n` is 0.
- R2: A byte address A hits when 0x400000 <= A <= 0xBFFFFF and the window is enabled. The word offset W = (A - 0x400000) >> 1, so address bit 0 is ignored. W splits into column W[7:0], bank W[9:8] and row W[21:10].
- R3: Commands appear as (RAS, CAS, WE) = (`pin_cs_n[0]`, `pin_cs_n[1]`, `pin_cs_n[2]`), active low. ACTIVE=011, READ=101, WRITE=100, PRECHARGE=010, NOP=111.
- R4: Suppose a hit is accepted at the end of cycle c. Cycle c+1 shows ACTIVE with `mem_addr` = row and `mem_ba` = bank, and cycle c+2 is NOP. Cycle c+3 shows READ or WRITE with `mem_addr` = column and `mem_addr[10]` = 0 (no auto-precharge).
- R5: `cas_lat` code n (0 to 3) means a latency of n+1 clocks. A READ in cycle k captures `mem_dq_in` at the end of cycle k+n+1. `rsp_valid` rises in the next cycle with that data.
- R6: In the WRITE cycle the block drives `mem_dq_oe`=1, `mem_dq_out` = write data and `mem_dqm` = ~`req_be`. `mem_dq_oe` is 0 in every other cycle. `rsp_valid` rises in the following cycle, and `rsp_rdata` keeps its previous value.
- R7: PRECHARGE with `mem_addr` = 0 (A10 low, single bank) and the same bank follows a WRITE in the next cycle, or follows the read capture in the next cycle. Exactly one NOP cycle (tRP) comes after it, and `req_ready` can be high in that cycle.
- R8: A request that misses, including any request while the window is disabled, is accepted. `err` is 1 for exactly the next cycle, the command pins stay NOP, and no response is produced.
- R9: `req_ready` is 1 only when no access is in flight (idle or the tRP cycle) and the response slot is empty or being drained. While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid` and `rsp_rdata` hold.
- R10: During reset the command pins show NOP, `rsp_valid`, `err` and `mem_dq_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also forwarded as SDRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| space_sel | input | 3 | Area space-select field; 3'b100 enables the window |
| cas_lat | input | 2 | CAS latency code, latency = code + 1 |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_addr | input | 24 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables (bit 1 = upper byte) |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Completion of a window access |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 16 | Read data |
| err | output | 1 | One-cycle pulse for a rejected request |
| pin_cs_n | output | 4 | Area 2..5 selects: RAS, CAS, WE, SDRAM clock |
| pin_oe_n | output | 1 | Output-enable pin used as CKE |
| mem_addr | output | 12 | Row / column address, bit 10 is precharge select |
| mem_ba | output | 2 | Bank address |
| mem_dqm | output | 2 | Byte write masks |
| mem_dq_out | output | 16 | Write data to SDRAM |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | 16 | Read data from SDRAM |

## Verification
The hardest case to reach is a new request that meets a response nobody has drained. The window must then decide whether to take the request in the tRP cycle, and that depends on `rsp_ready` in the same cycle. The bench reaches it with a phase where `rsp_ready` follows a pseudo-random bit while requests are offered back to back. The model predicts `req_ready` from its own free cycle and response slot each clock. The CAS latency is checked with a memory model on the pins that puts valid data on `mem_dq_in` only in the one correct cycle, and junk in every other cycle. All four latency codes are exercised.

// File: rtl/sdwin_pkg.sv
package sdwin_pkg;
  // command bits are {RAS, CAS, WE}, active low
  typedef enum logic [2:0] {
    CMD_NOP = 3'b111,
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_WR  = 3'b100,
    CMD_PRE = 3'b010
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_RCD, ST_RW, ST_LAT, ST_PRE, ST_TRP
  } sd_state_e;

  localparam logic [2:0] SPACE_SDRAM = 3'b100;
endpackage

// File: rtl/sdwin_decode.sv
module sdwin_decode import sdwin_pkg::*; #(
  parameter int ADDR_W     = 24,
  parameter int AREA_W     = 21,
  parameter int FIRST_AREA = 2,
  parameter int N_AREAS    = 4,
  parameter int COL_W      = 8,
  parameter int BA_W       = 2,
  parameter int ROW_W      = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        space_sel,
  output logic              win_en,
  output logic              hit,
  output logic [COL_W-1:0]  col,
  output logic [BA_W-1:0]   bank,
  output logic [ROW_W-1:0]  row
);
  localparam int WIN_W = AREA_W + $clog2(N_AREAS);
  localparam int WORD_W = WIN_W - 1;
  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(FIRST_AREA) << AREA_W;
  localparam logic [ADDR_W:0] WIN_HI = WIN_LO + ((ADDR_W+1)'(N_AREAS) << AREA_W);

  logic [ADDR_W-1:0] off;
  logic [WORD_W-1:0] word;
  logic              in_range;

  assign win_en   = (space_sel == SPACE_SDRAM);
  assign in_range = ({1'b0, addr} >= WIN_LO) && ({1'b0, addr} < WIN_HI);
  assign hit      = win_en && in_range;
  assign off      = addr - WIN_LO[ADDR_W-1:0];
  assign word     = WORD_W'(off >> 1);
  assign col      = word[COL_W-1:0];
  assign bank     = word[COL_W +: BA_W];
  assign row      = word[COL_W+BA_W +: ROW_W];
endmodule

// File: rtl/sdwin_seq.sv
module sdwin_seq import sdwin_pkg::*; #(
  parameter int DATA_W   = 16,
  parameter int COL_W    = 8,
  parameter int BA_W     = 2,
  parameter int ROW_W    = 12,
  parameter int MA_W     = 12,
  parameter int PSEL_BIT = 10,
  parameter int CL_W     = 2,
  localparam int BE_W    = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              hit,
  input  logic [COL_W-1:0]  col,
  input  logic [BA_W-1:0]   bank,
  input  logic [ROW_W-1:0]  row,
  input  logic [CL_W-1:0]   cas_lat,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              err,
  output sd_cmd_e           cmd,
  output logic [MA_W-1:0]   ma,
  output logic [BA_W-1:0]   ba,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [BE_W-1:0]   dqm,
  input  logic [DATA_W-1:0] dq_in
);
  sd_state_e         st;
  logic [CL_W-1:0]   lat_cnt;
  logic              wr_q;
  logic [COL_W-1:0]  col_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] wd_q;
  logic              acc;
  logic [MA_W-1:0]   col_ma;

  assign req_ready = (st == ST_IDLE || st == ST_TRP) && (!rsp_valid || rsp_ready);
  assign acc       = req_valid && req_ready;

  always_comb begin
    col_ma = MA_W'(col_q);
    col_ma[PSEL_BIT] = 1'b0;  // no auto-precharge
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cmd       <= CMD_NOP;
      ma        <= '0;
      ba        <= '0;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      dqm       <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      err       <= 1'b0;
      lat_cnt   <= '0;
      wr_q      <= 1'b0;
      col_q     <= '0;
      be_q      <= '0;
      wd_q      <= '0;
    end else begin
      cmd   <= CMD_NOP;
      dq_oe <= 1'b0;
      dqm   <= '0;
      err   <= 1'b0;
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      case (st)
        ST_IDLE, ST_TRP: begin
          st <= ST_IDLE;
          if (acc) begin
            if (hit) begin
              st    <= ST_ACT;
              cmd   <= CMD_ACT;
              ma    <= MA_W'(row);
              ba    <= bank;
              wr_q  <= req_write;
              col_q <= col;
              be_q  <= req_be;
              wd_q  <= req_wdata;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_ACT: st <= ST_RCD;
        ST_RCD: begin
          st  <= ST_RW;
          cmd <= wr_q ? CMD_WR : CMD_RD;
          ma  <= col_ma;
          if (wr_q) begin
            dq_oe  <= 1'b1;
            dq_out <= wd_q;
            dqm    <= ~be_q;
          end
        end
        ST_RW: begin
          if (wr_q) begin
            st        <= ST_PRE;
            cmd       <= CMD_PRE;
            ma        <= '0;
            rsp_valid <= 1'b1;
          end else begin
            st      <= ST_LAT;
            lat_cnt <= cas_lat;
          end
        end
        ST_LAT: begin
          if (lat_cnt == '0) begin
            st        <= ST_PRE;
            cmd       <= CMD_PRE;
            ma        <= '0;
            rsp_valid <= 1'b1;
            rsp_rdata <= dq_in;
          end else begin
            lat_cnt <= lat_cnt - 1'b1;
          end
        end
        ST_PRE:  st <= ST_TRP;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // tRCD: a column command is always two cycles behind its ACTIVE
  assert_rcd_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_WR) |-> $past(cmd, 2) == CMD_ACT);

  // tRP: the cycle after PRECHARGE carries no command
  assert_trp_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRE) |=> (cmd == CMD_NOP));

  // response holds under back-pressure
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // a rejected request never reaches the command pins
  assert_err_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cmd == CMD_NOP));

  // data bus is driven only together with WRITE
  assert_wr_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (cmd == CMD_WR));

  // a request is never taken while the response slot stays blocked
  assert_no_overrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: rtl/sdwin_pins.sv
module sdwin_pins import sdwin_pkg::*; (
  input  logic       clk,
  input  logic       win_en,
  input  sd_cmd_e    cmd,
  output logic [3:0] pin_cs_n,
  output logic       pin_oe_n
);
  logic [2:0] cbits;
  assign cbits = cmd;

  always_comb begin
    if (win_en) begin
      pin_cs_n = {clk, cbits[0], cbits[1], cbits[2]};
    end else begin
      pin_cs_n = 4'b1111;
    end
    pin_oe_n = win_en;  // acts as CKE
  end
endmodule

// File: rtl/sdwin_bus_if.sv
module sdwin_bus_if import sdwin_pkg::*; #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int AREA_W     = 21,
  parameter int FIRST_AREA = 2,
  parameter int N_AREAS    = 4,
  parameter int COL_W      = 8,
  parameter int BA_W       = 2,
  parameter int PSEL_BIT   = 10,
  parameter int CL_W       = 2,
  localparam int BE_W      = DATA_W / 8,
  localparam int WIN_W     = AREA_W + $clog2(N_AREAS),
  localparam int ROW_W     = WIN_W - 1 - COL_W - BA_W,
  localparam int MA_W      = (ROW_W > PSEL_BIT) ? ROW_W : PSEL_BIT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        space_sel,
  input  logic [CL_W-1:0]   cas_lat,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              err,
  output logic [3:0]        pin_cs_n,
  output logic              pin_oe_n,
  output logic [MA_W-1:0]   mem_addr,
  output logic [BA_W-1:0]   mem_ba,
  output logic [BE_W-1:0]   mem_dqm,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  logic             win_en;
  logic             hit;
  logic [COL_W-1:0] col;
  logic [BA_W-1:0]  bank;
  logic [ROW_W-1:0] row;
  sd_cmd_e          cmd;

  sdwin_decode #(
    .ADDR_W(ADDR_W), .AREA_W(AREA_W), .FIRST_AREA(FIRST_AREA),
    .N_AREAS(N_AREAS), .COL_W(COL_W), .BA_W(BA_W), .ROW_W(ROW_W)
  ) u_decode (
    .addr(req_addr), .space_sel(space_sel), .win_en(win_en), .hit(hit),
    .col(col), .bank(bank), .row(row)
  );

  sdwin_seq #(
    .DATA_W(DATA_W), .COL_W(COL_W), .BA_W(BA_W), .ROW_W(ROW_W),
    .MA_W(MA_W), .PSEL_BIT(PSEL_BIT), .CL_W(CL_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata),
    .hit(hit), .col(col), .bank(bank), .row(row), .cas_lat(cas_lat),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .err(err), .cmd(cmd), .ma(mem_addr), .ba(mem_ba), .dq_out(mem_dq_out),
    .dq_oe(mem_dq_oe), .dqm(mem_dqm), .dq_in(mem_dq_in)
  );

  sdwin_pins u_pins (
    .clk(clk), .win_en(win_en), .cmd(cmd), .pin_cs_n(pin_cs_n), .pin_oe_n(pin_oe_n)
  );

  // disabled window keeps the command pins quiet and CKE low
  assert_quiet_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_en) |-> (pin_cs_n[2:0] == 3'b111 && !pin_oe_n));
endmodule

// File: tb/sdwin_bus_if_tb.sv
module sdwin_bus_if_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  space_sel = 3'b100;
  logic [1:0]  cas_lat = 2'd0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_be = 2'b11;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;
  logic        err;
  logic [3:0]  pin_cs_n;
  logic        pin_oe_n;
  logic [11:0] mem_addr;
  logic [1:0]  mem_ba;
  logic [1:0]  mem_dqm;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in = '0;

  sdwin_bus_if u_dut (.*);

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit bp_mode = 0;
  logic [7:0] lfsr = 8'hA5;

  // SDRAM-side model state
  int open_row [4];
  logic [15:0] smem [int];
  int rd_due = -100;
  logic [15:0] rd_val = '0;

  // CPU-side reference model
  logic [15:0] cmem [int];
  int t_s = -100, t_pre = -100, t_free = 0, err_c = -100;
  bit t_wr = 0;
  int t_row = 0, t_bank = 0, t_col = 0;
  logic [15:0] t_wd = '0, t_rd = '0;
  logic [1:0] t_be = '0;
  bit erv = 0;
  logic [15:0] erd = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // clock-side stimulus: cycle count, SDRAM read data, response back-pressure
  initial begin
    forever begin
      @(posedge clk);
      cyc = cyc + 1;
      #1;
      mem_dq_in = (cyc == rd_due) ? rd_val : (16'hBAD0 ^ cyc[15:0]);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rsp_ready = bp_mode ? lfsr[0] : 1'b1;
    end
  end

  function automatic bit in_win(input logic [23:0] a);
    return (space_sel == 3'b100) && (a >= 24'h400000) && (a <= 24'hBFFFFF);
  endfunction

  task automatic model_step();
    int c;
    logic [2:0] ecmd, acmd;
    logic [11:0] ema;
    bit win, eready;
    c = cyc;
    win = (space_sel == 3'b100);
    if (c == t_pre) begin
      erv = 1;
      if (!t_wr) erd = t_rd;
    end
    ecmd = 3'b111; ema = '0;
    if (c == t_s + 1) begin ecmd = 3'b011; ema = 12'(t_row); end
    else if (c == t_s + 3) begin ecmd = t_wr ? 3'b100 : 3'b101; ema = 12'(t_col); end
    else if (c == t_pre) begin ecmd = 3'b010; ema = '0; end
    eready = (c >= t_free) && (!erv || rsp_ready);
    acmd = pin_cs_n[2:0];
    acmd = {pin_cs_n[0], pin_cs_n[1], pin_cs_n[2]};

    // R1 window pins
    chk(pin_oe_n == win, "R1", "cke", pin_oe_n, win);
    chk(pin_cs_n[3] == !win, "R1", "sdram clock pin at low phase", pin_cs_n[3], !win);
    if (!win) chk(pin_cs_n == 4'hF, "R1", "selects when disabled", pin_cs_n, 4'hF);
    // R3/R4/R7 command and address
    if (win) chk(acmd == ecmd, "R3", "command", acmd, ecmd);
    if (ecmd != 3'b111) begin
      chk(mem_addr == ema, "R4", "address pins", mem_addr, ema);
      chk(mem_ba == 2'(t_bank), "R2", "bank pins", mem_ba, t_bank);
    end
    // R6 write drive
    chk(mem_dq_oe == (c == t_s + 3 && t_wr), "R6", "dq drive", mem_dq_oe, (c == t_s + 3 && t_wr));
    if (c == t_s + 3 && t_wr) begin
      chk(mem_dq_out == t_wd, "R6", "write data", mem_dq_out, t_wd);
      chk(mem_dqm == ~t_be, "R6", "byte masks", mem_dqm, ~t_be);
    end
    // R8 error pulse
    chk(err == (c == err_c), "R8", "error flag", err, (c == err_c));
    // R9 handshake and response
    chk(req_ready == eready, "R9", "req_ready", req_ready, eready);
    chk(rsp_valid == erv, "R9", "rsp_valid", rsp_valid, erv);
    if (erv) chk(rsp_rdata == erd, "R5", "read data", rsp_rdata, erd);

    // SDRAM memory model on the pins
    if (win) begin
      if (acmd == 3'b011) open_row[mem_ba] = int'(mem_addr);
      if (acmd == 3'b100) begin
        int key;
        logic [15:0] v;
        key = (int'(mem_ba) << 20) | (open_row[mem_ba] << 8) | int'(mem_addr[7:0]);
        v = smem.exists(key) ? smem[key] : 16'h0;
        if (!mem_dqm[0]) v[7:0] = mem_dq_out[7:0];
        if (!mem_dqm[1]) v[15:8] = mem_dq_out[15:8];
        smem[key] = v;
      end
      if (acmd == 3'b101) begin
        int key;
        key = (int'(mem_ba) << 20) | (open_row[mem_ba] << 8) | int'(mem_addr[7:0]);
        rd_val = smem.exists(key) ? smem[key] : 16'h0;
        rd_due = c + int'(cas_lat) + 1;
      end
    end

    // handshakes at the end of this cycle
    if (erv && rsp_ready) erv = 0;
    if (req_valid && eready) begin
      if (in_win(req_addr)) begin
        int w;
        logic [15:0] v;
        w = int'((req_addr - 24'h400000) >> 1);
        t_s = c; t_wr = req_write; t_wd = req_wdata; t_be = req_be;
        t_col = w & 255; t_bank = (w >> 8) & 3; t_row = (w >> 10) & 4095;
        t_pre = req_write ? c + 4 : c + 5 + int'(cas_lat);
        t_free = t_pre + 1;
        v = cmem.exists(w) ? cmem[w] : 16'h0;
        if (req_write) begin
          if (req_be[0]) v[7:0] = req_wdata[7:0];
          if (req_be[1]) v[15:8] = req_wdata[15:8];
          cmem[w] = v;
        end else t_rd = v;
      end else begin
        err_c = c + 1;
      end
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) model_step();
    end
  end

  task automatic do_req(input logic [23:0] a, input bit wr, input logic [1:0] be,
                        input logic [15:0] d);
    bit ok;
    @(posedge clk); #1;
    req_valid = 1; req_addr = a; req_write = wr; req_be = be; req_wdata = d;
    do begin
      @(negedge clk); #3;
      ok = req_ready;
      if (!ok) @(posedge clk);
    end while (!ok);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic settle();
    repeat (14) @(posedge clk);
  endtask

  task automatic run_all();
    // R10 reset state
    repeat (3) @(negedge clk);
    chk({pin_cs_n[0], pin_cs_n[1], pin_cs_n[2]} == 3'b111, "R10", "cmd in reset",
        {pin_cs_n[0], pin_cs_n[1], pin_cs_n[2]}, 3'b111);
    chk(rsp_valid == 0, "R10", "rsp_valid in reset", rsp_valid, 0);
    chk(err == 0, "R10", "err in reset", err, 0);
    chk(mem_dq_oe == 0, "R10", "dq drive in reset", mem_dq_oe, 0);
    @(posedge clk); #1; rst_n = 1;
    settle();

    // R4 R5 R6 basic write and read-back at every CAS latency
    cas_lat = 2'd0;
    do_req(24'h400000, 1, 2'b11, 16'h1234); settle();
    do_req(24'h400000, 0, 2'b11, 16'h0);    settle();
    do_req(24'h402CFE, 1, 2'b11, 16'hC0DE); settle();  // R2 row 5 bank 2 col 7F
    for (int n = 0; n < 4; n++) begin
      cas_lat = 2'(n);
      settle();
      do_req(24'h402CFE, 0, 2'b11, 16'h0); settle();
      do_req(24'h400001, 0, 2'b11, 16'h0); settle();  // R2 bit 0 ignored
    end
    // R2 upper boundary and byte enables (R6)
    cas_lat = 2'd2; settle();
    do_req(24'hBFFFFE, 1, 2'b11, 16'h5A5A); settle();
    do_req(24'hBFFFFE, 1, 2'b10, 16'hABCD); settle();
    do_req(24'hBFFFFF, 1, 2'b01, 16'h00EF); settle();
    do_req(24'hBFFFFE, 0, 2'b11, 16'h0);    settle();
    do_req(24'h7FFFFE, 1, 2'b11, 16'h7777); settle();
    do_req(24'h7FFFFE, 0, 2'b11, 16'h0);    settle();
    // R8 misses just outside the window
    do_req(24'h3FFFFE, 1, 2'b11, 16'hFFFF); settle();
    do_req(24'hC00000, 0, 2'b11, 16'h0);    settle();
    // R1 R8 window disabled: reserved, normal and other codes
    space_sel = 3'b111; settle();
    do_req(24'h400000, 1, 2'b11, 16'h9999); settle();
    space_sel = 3'b000; settle();
    do_req(24'h400000, 0, 2'b11, 16'h0); settle();
    space_sel = 3'b010; settle();
    do_req(24'h600000, 1, 2'b11, 16'h8888); settle();
    space_sel = 3'b100; settle();
    do_req(24'h400000, 0, 2'b11, 16'h0); settle();  // R8 disabled writes left no trace
    // R7 R9 back-to-back traffic under random response back-pressure
    cas_lat = 2'd1; bp_mode = 1; settle();
    for (int i = 0; i < 24; i++) begin
      logic [23:0] a;
      a = 24'h400000 + 24'(i % 6) * 24'h000802;
      do_req(a, (i % 3) != 2, 2'(i % 4) | 2'b01, 16'(i * 16'h1111 + 3));
      if (i == 10) do_req(24'h0000FE, 0, 2'b11, 16'h0);  // R8 miss among hits
    end
    bp_mode = 0;
    settle();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule